// File: doc/BRIEF.md
# I2C Interrupt Flag and Clear Controller

This block collects the event and error indications of an I2C/SMBus controller into one 13-bit status word. Each status bit is set by a one-cycle pulse from the protocol engine and remains set until the register-access side effect that belongs to that bit takes place. Depending on the bit, that side effect is a read of the receive data register, a write of the transmit data register, a reload write to the second control register with a nonzero byte count, a START or STOP request, or a write-1 clear bit.

Every status bit is masked by an enable. The transfer-related bits each have their own enable. The six error bits share one common enable. The masked bits are ORed together into a single interrupt request, which is registered before it leaves the block. The register file decodes the bus accesses into the strobes this block takes. The status word is returned to software through that register file.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bit of `flags_o` and `irq_o` is 0 after that edge.
- R2: A 1 on bit k of `event_i` at a clock edge sets `flags_o[k]` after that edge. The bit map is: 0 receive-not-empty, 1 transmit-ready, 2 stop-seen, 3 reload-pending, 4 transfer-done, 5 address-hit, 6 nack-seen, 7 bus-error, 8 arbitration-lost, 9 overrun/underrun, 10 PEC-error, 11 clock-timeout, 12 SMBus-alert.
- R3: `rd_rxdata_i` clears bit 0.
- R4: `wr_txdata_i` clears bit 1.
- R5: `wr_ctrl2_i` clears bit 3 only when `ctrl2_count_i` is nonzero. With a zero count, bit 3 keeps its value.
- R6: `wr_start_i` or `wr_stop_i` clears bit 4.
- R7: A 1 on bit 2, 5 or 6 of `w1c_i` clears the status bit at the same position. Bits 0, 1, 3 and 4 of `w1c_i` have no effect.
- R8: A 1 on any of bits 7 to 12 of `w1c_i` clears the error status bit at the same position.
- R9: If a set pulse and that bit's clear action occur in the same cycle, the bit is 1 afterwards.
- R10: `irq_o` is the OR over k of `flags_o[k]` AND its enable, registered one cycle. Bits 0 to 6 use `irq_en_i[k]`. Bits 7 to 12 all use `irq_en_i[7]`.
- R11: A status bit that has neither a set pulse nor its clear action in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| event_i | input | 13 | One-cycle set pulses from the protocol engine |
| rd_rxdata_i | input | 1 | Receive data register read strobe |
| wr_txdata_i | input | 1 | Transmit data register write strobe |
| wr_ctrl2_i | input | 1 | Control register 2 write strobe |
| ctrl2_count_i | input | 8 | Byte-count field of the control register 2 write |
| wr_start_i | input | 1 | START=1 write strobe |
| wr_stop_i | input | 1 | STOP=1 write strobe |
| w1c_i | input | 13 | Write-1 clear bits, aligned to the status bits |
| irq_en_i | input | 8 | Interrupt enables (7 = shared error enable) |
| flags_o | output | 13 | Status bits |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check the following properties: a set pulse always leaves its bit high; a clear without a coincident set drops the bit; a bit with no activity stays unchanged; a zero-count reload write never produces a clear; and the interrupt line follows the masked status word, including the shared error enable. Other behaviour can only be shown by the bench's scenarios, which are compared every cycle against a behavioural model. This covers which strobe is tied to which bit, that the non-clearing positions of the write-1 clear vector are ignored, and the exact one-cycle lag of the interrupt after each combination of enables.

// File: rtl/i2c_irq_pkg.sv
// Package: bit positions, clear-rule kinds and enable mapping shared by the
// interrupt flag controller and its sub-blocks.
package i2c_irq_pkg;

    localparam int NFLAG   = 13;
    localparam int NEN     = 8;
    localparam int CNT_W   = 8;

    localparam int F_RXNE  = 0;
    localparam int F_TXI   = 1;
    localparam int F_STOP  = 2;
    localparam int F_RLD   = 3;
    localparam int F_DONE  = 4;
    localparam int F_ADDR  = 5;
    localparam int F_NACK  = 6;
    localparam int F_ERR0  = 7;   // first of the error bits 7..12

    localparam int EN_ERR  = 7;

    // How a status bit is cleared
    typedef enum logic [2:0] {
        CR_DATA_RD   = 3'd0,
        CR_DATA_WR   = 3'd1,
        CR_RELOAD    = 3'd2,
        CR_STARTSTOP = 3'd3,
        CR_W1C       = 3'd4
    } clr_rule_t;

    // Clear rule chosen per status bit
    function automatic clr_rule_t rule_of(input int idx);
        case (idx)
            F_RXNE:  return CR_DATA_RD;
            F_TXI:   return CR_DATA_WR;
            F_RLD:   return CR_RELOAD;
            F_DONE:  return CR_STARTSTOP;
            default: return CR_W1C;
        endcase
    endfunction

    // Enable index for a status bit: error bits share one enable
    function automatic int en_of(input int idx);
        return (idx >= F_ERR0) ? EN_ERR : idx;
    endfunction

endpackage

// File: rtl/i2c_flag_cell.sv
// One sticky status bit. A set pulse takes priority over a clear in the same
// cycle. Assumes set and clear are single-cycle, synchronous to clk.
module i2c_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Sticky bit update: set wins, otherwise clear, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));

endmodule

// File: rtl/i2c_clear_decode.sv
// Turns register-access strobes into one clear request per status bit,
// following each bit's clear rule. Assumes strobes are single-cycle.
module i2c_clear_decode
    import i2c_irq_pkg::*;
#(
    parameter int N  = NFLAG,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_rxdata_i,
    input  logic          wr_txdata_i,
    input  logic          wr_ctrl2_i,
    input  logic [CW-1:0] ctrl2_count_i,
    input  logic          wr_start_i,
    input  logic          wr_stop_i,
    input  logic [N-1:0]  w1c_i,
    output logic [N-1:0]  clr_o
);

    logic          reload_ok;
    logic [N-1:0]  unused_w1c;

    // Reload clear qualifies only with a nonzero byte count
    assign reload_ok = wr_ctrl2_i && (ctrl2_count_i != '0);

    // Pick the clear source of every bit from its rule
    for (genvar k = 0; k < N; k++) begin : g_clr
        localparam clr_rule_t RULE = rule_of(k);
        if (RULE == CR_DATA_RD) begin : g_rd
            assign clr_o[k]      = rd_rxdata_i;
            assign unused_w1c[k] = w1c_i[k];
        end else if (RULE == CR_DATA_WR) begin : g_wr
            assign clr_o[k]      = wr_txdata_i;
            assign unused_w1c[k] = w1c_i[k];
        end else if (RULE == CR_RELOAD) begin : g_rl
            assign clr_o[k]      = reload_ok;
            assign unused_w1c[k] = w1c_i[k];
        end else if (RULE == CR_STARTSTOP) begin : g_ss
            assign clr_o[k]      = wr_start_i | wr_stop_i;
            assign unused_w1c[k] = w1c_i[k];
        end else begin : g_w1c
            assign clr_o[k]      = w1c_i[k];
            assign unused_w1c[k] = 1'b0;
        end
    end

    assert_zero_count_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl2_i && ctrl2_count_i == '0) |-> !clr_o[F_RLD]);
    assert_startstop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start_i || wr_stop_i) |-> clr_o[F_DONE]);

endmodule

// File: rtl/i2c_irq_merge.sv
// Masks each status bit with its enable and registers the OR as the
// interrupt request. Assumes enables are static relative to one cycle.
module i2c_irq_merge
    import i2c_irq_pkg::*;
#(
    parameter int N  = NFLAG,
    parameter int NE = NEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  flags_i,
    input  logic [NE-1:0] en_i,
    output logic          irq_o
);

    logic [N-1:0] masked;
    logic         irq_q;

    // Route each bit through its own or the shared enable
    for (genvar k = 0; k < N; k++) begin : g_mask
        localparam int EI = en_of(k);
        assign masked[k] = flags_i[k] & en_i[EI];
    end

    // Register the combined request
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |masked;
    end

    assign irq_o = irq_q;

    assert_quiet_when_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_i == '0) |=> !irq_o);
    assert_shared_err_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|flags_i[N-1:F_ERR0]) && en_i[EN_ERR]) |=> irq_o);

endmodule

// File: rtl/i2c_irq_ctrl.sv
// Top: status bits of an I2C/SMBus controller with per-bit clear side
// effects and a single registered interrupt. Assumes all strobes and event
// pulses are single-cycle and synchronous to clk.
module i2c_irq_ctrl
    import i2c_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] event_i,
    input  logic             rd_rxdata_i,
    input  logic             wr_txdata_i,
    input  logic             wr_ctrl2_i,
    input  logic [CNT_W-1:0] ctrl2_count_i,
    input  logic             wr_start_i,
    input  logic             wr_stop_i,
    input  logic [NFLAG-1:0] w1c_i,
    input  logic [NEN-1:0]   irq_en_i,
    output logic [NFLAG-1:0] flags_o,
    output logic             irq_o
);

    logic [NFLAG-1:0] clr_vec;

    i2c_clear_decode #(.N(NFLAG), .CW(CNT_W)) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_rxdata_i   (rd_rxdata_i),
        .wr_txdata_i   (wr_txdata_i),
        .wr_ctrl2_i    (wr_ctrl2_i),
        .ctrl2_count_i (ctrl2_count_i),
        .wr_start_i    (wr_start_i),
        .wr_stop_i     (wr_stop_i),
        .w1c_i         (w1c_i),
        .clr_o         (clr_vec)
    );

    // One sticky cell per status bit
    for (genvar k = 0; k < NFLAG; k++) begin : g_flag
        i2c_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (event_i[k]),
            .clr_i  (clr_vec[k]),
            .flag_o (flags_o[k])
        );
    end

    i2c_irq_merge #(.N(NFLAG), .NE(NEN)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags_i (flags_o),
        .en_i    (irq_en_i),
        .irq_o   (irq_o)
    );

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (flags_o == '0 && !irq_o));
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i != '0) |=> ((flags_o & $past(event_i)) == $past(event_i)));

endmodule

// File: tb/tb_i2c_irq_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] event_i;
    logic        rd_rxdata_i, wr_txdata_i, wr_ctrl2_i, wr_start_i, wr_stop_i;
    logic [7:0]  ctrl2_count_i;
    logic [12:0] w1c_i;
    logic [7:0]  irq_en_i;
    logic [12:0] flags_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference state
    bit [12:0] m_flags;
    bit        m_irq;

    always #2.5 clk = ~clk;

    i2c_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .event_i(event_i),
        .rd_rxdata_i(rd_rxdata_i), .wr_txdata_i(wr_txdata_i),
        .wr_ctrl2_i(wr_ctrl2_i), .ctrl2_count_i(ctrl2_count_i),
        .wr_start_i(wr_start_i), .wr_stop_i(wr_stop_i),
        .w1c_i(w1c_i), .irq_en_i(irq_en_i),
        .flags_o(flags_o), .irq_o(irq_o)
    );

    function automatic int enable_for(int k);
        if (k <= 6) return k;
        return 7;
    endfunction

    function automatic bit clear_for(int k);
        case (k)
            0: return rd_rxdata_i;
            1: return wr_txdata_i;
            3: return wr_ctrl2_i && (ctrl2_count_i > 0);
            4: return wr_start_i || wr_stop_i;
            default: return w1c_i[k];
        endcase
    endfunction

    task automatic idle();
        event_i = '0; rd_rxdata_i = 0; wr_txdata_i = 0; wr_ctrl2_i = 0;
        ctrl2_count_i = '0; wr_start_i = 0; wr_stop_i = 0; w1c_i = '0;
    endtask

    // Advance one clock, update model, compare, return inputs to idle
    task automatic step(input string tag);
        bit nirq;
        @(posedge clk); #1;
        if (!rst_n) begin
            m_flags = '0; m_irq = 0;
        end else begin
            nirq = 0;
            for (int k = 0; k < 13; k++)
                if (m_flags[k] && irq_en_i[enable_for(k)]) nirq = 1;
            for (int k = 0; k < 13; k++) begin
                if (event_i[k]) m_flags[k] = 1;
                else if (clear_for(k)) m_flags[k] = 0;
            end
            m_irq = nirq;
        end
        checks++;
        if (flags_o !== m_flags || irq_o !== m_irq) begin
            fails++;
            $display("FAIL %s flags=%h irq=%b expected flags=%h irq=%b",
                     tag, flags_o, irq_o, m_flags, m_irq);
        end
        idle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        irq_en_i = '0;
        rst_n = 0;
        m_flags = '0; m_irq = 0;
        event_i = '1;
        step("R1");
        step("R1");
        rst_n = 1;
        step("R1");

        // R2: every event bit sets its flag, then R11 hold
        event_i = 13'h1FFF; step("R2");
        step("R11"); step("R11");

        // R3 / R4: data read and write
        rd_rxdata_i = 1; step("R3");
        wr_txdata_i = 1; step("R4");

        // R5: zero count keeps, nonzero clears
        wr_ctrl2_i = 1; ctrl2_count_i = 0; step("R5");
        wr_ctrl2_i = 1; ctrl2_count_i = 8'd5; step("R5");

        // R6: start then stop clear transfer-done
        wr_start_i = 1; step("R6");
        event_i[4] = 1; step("R6");
        wr_stop_i = 1; step("R6");

        // R7: re-set 0,1,3,4; w1c on those positions is ignored
        event_i = 13'h001B; step("R7");
        w1c_i = 13'h001B; step("R7");
        w1c_i = 13'h0064; step("R7");

        // R8: error bits cleared one at a time
        for (int k = 7; k < 13; k++) begin
            w1c_i = 13'(1 << k); step("R8");
        end

        // R9: set and clear together
        event_i = 13'h1FFF; rd_rxdata_i = 1; wr_txdata_i = 1; wr_ctrl2_i = 1;
        ctrl2_count_i = 8'd1; wr_start_i = 1; w1c_i = 13'h1FFF; step("R9");

        // R10: each enable alone against a single flag
        w1c_i = 13'h1FE4; rd_rxdata_i = 1; wr_txdata_i = 1; wr_ctrl2_i = 1;
        ctrl2_count_i = 8'd3; wr_stop_i = 1; step("R10");
        for (int k = 0; k < 13; k++) begin
            irq_en_i = 8'(1 << enable_for(k));
            event_i = 13'(1 << k); step("R10");
            step("R10");
            irq_en_i = 8'(~(1 << enable_for(k))); step("R10");
            step("R10");
            irq_en_i = '0;
            w1c_i = 13'h1FE4; rd_rxdata_i = 1; wr_txdata_i = 1; wr_ctrl2_i = 1;
            ctrl2_count_i = 8'd9; wr_stop_i = 1; step("R10");
        end

        // R11 and mixed: random traffic
        for (int i = 0; i < 3000; i++) begin
            irq_en_i = 8'($urandom);
            event_i = 13'($urandom & $urandom & $urandom);
            rd_rxdata_i = ($urandom % 4) == 0;
            wr_txdata_i = ($urandom % 4) == 0;
            wr_ctrl2_i  = ($urandom % 4) == 0;
            ctrl2_count_i = (($urandom % 2) == 0) ? 8'd0 : 8'($urandom);
            wr_start_i = ($urandom % 6) == 0;
            wr_stop_i  = ($urandom % 6) == 0;
            w1c_i = 13'($urandom & $urandom);
            step("R11");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule